// File: doc/BRIEF.md
# Sigma-Delta Decimation Filter Controller

This block turns the one-bit output of a sigma-delta modulator into decimated result words. Each modulator bit arrives with a strobe. It passes through a cascade of integrators that run at the strobe rate and then through comb stages that run once per output period. The filter order can be switched at run time between a third-order sinc response, for low noise, and a first-order sinc response, which settles quickly. A two-bit select picks one of four parameterised decimation ratios.

The block tracks how many output periods have passed since the filter last restarted. It latches a result only once that result reflects fully settled data, and at that moment it raises a data-ready flag. Any configuration change restarts the filter and drops the flag. A configuration change is a pulse on the change input, or a new value on the order select or the ratio select. A hold input freezes the filter in its cleared state but leaves the flag alone. A read strobe clears the flag, and it does so while the hold input is high as well.

Top module: `sdm_decim_ctrl`

## Requirements
- R1: With `fast_sel_i`=0 the settled result is bits [ACC_W-1:ACC_W-OUT_W] of a third-order sinc sum, where a modulator bit of 1 counts as 1 and a bit of 0 counts as 0. With ACC_W=19 and OUT_W=18, ratio R, all-ones input gives R^3/2 and alternating input gives R^3/4.
- R2: With `fast_sel_i`=1 the settled result is the same bit slice of a first-order sum: R/2 for all-ones input.
- R3: In third-order mode, `drdy_o` stays low until the 3R-th accepted strobe after a restart, and rises on the edge that accepts that strobe.
- R4: In first-order mode, `drdy_o` rises on the edge that accepts the R-th strobe after a restart.
- R5: A pulse on `cfg_chg_i`, or a change of `fast_sel_i` or `ratio_sel_i`, clears `drdy_o` at the next edge. It also clears the filter and the counters, and discards any strobe in that cycle. A switch from first order to third order therefore needs three new output periods.
- R6: While `sync_hold_i`=1 the filter is held cleared and strobes are ignored: `result_o` does not change and `drdy_o` is not cleared by the hold.
- R7: A `rd_stb_i` pulse clears `drdy_o` at the next edge, including while `sync_hold_i`=1. It leaves `result_o` unchanged.
- R8: If a settled result is latched in the same cycle as `rd_stb_i`, the new word is stored and `drdy_o` stays 1.
- R9: A new settled word overwrites `result_o` and keeps `drdy_o` set without any read in between.
- R10: `ratio_sel_i` values 0, 1, 2 and 3 select RATIO0..RATIO3 strobes per output period (defaults 8, 16, 32, 64).
- R11: After `sync_hold_i` is released, settling counts again from zero output periods.
- R12: After reset, `result_o`=0 and `drdy_o`=0.
- R13: Integrators and combs wrap in two's complement on ACC_W = 3*ceil(log2(max ratio))+1 bits. With ratio 64, all-ones third-order input gives result 131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit_i | input | 1 | Modulator bit |
| mod_stb_i | input | 1 | Modulator bit valid strobe |
| fast_sel_i | input | 1 | 0 = third-order sinc, 1 = first-order sinc |
| ratio_sel_i | input | 2 | Decimation ratio select |
| sync_hold_i | input | 1 | Hold the filter cleared while high |
| cfg_chg_i | input | 1 | Configuration-change pulse |
| rd_stb_i | input | 1 | Data read strobe, clears data-ready |
| result_o | output | OUT_W | Latched settled result |
| drdy_o | output | 1 | Data-ready flag |

## Verification
A read strobe and the latch of a new settled word can land on the same edge. In that case the read is meant to lose. The bench lines up a read pulse with the strobe that completes a first-order output period, so both happen on one edge. It then expects the new word on the result port with the flag still high. A separate read on an idle cycle shows that the flag does clear when no latch competes with it.

// File: rtl/sdm_decim_pkg.sv
package sdm_decim_pkg;

   typedef enum logic {
      FILT_SINC3 = 1'b0,
      FILT_SINC1 = 1'b1
   } filt_e;

   localparam int         SINC_ORDER   = 3;
   localparam logic [1:0] SETTLE_SINC3 = 2'd3;
   localparam logic [1:0] SETTLE_SINC1 = 2'd1;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/sdm_integ_chain.sv
module sdm_integ_chain #(
   parameter int ORDER = 3,
   parameter int ACC_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic             din_i,
   output logic [ACC_W-1:0] first_o,
   output logic [ACC_W-1:0] last_o
);

   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      logic [ACC_W-1:0] acc_q;
      logic [ACC_W-1:0] sum;

      if (g == 0) begin : g_head
         assign sum = acc_q + {{(ACC_W-1){1'b0}}, din_i};
      end else begin : g_tail
         assign sum = acc_q + g_stage[g-1].sum;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     acc_q <= '0;
         else if (clr_i) acc_q <= '0;
         else if (en_i)  acc_q <= sum;
      end

      // R6: a hold or restart leaves every integrator at zero
      p_integ_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
         clr_i |=> (acc_q == '0));
   end

   assign first_o = g_stage[0].sum;
   assign last_o  = g_stage[ORDER-1].sum;

endmodule

// File: rtl/sdm_comb_chain.sv
module sdm_comb_chain #(
   parameter int ORDER = 3,
   parameter int ACC_W = 19
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic [ACC_W-1:0] din_i,
   output logic [ACC_W-1:0] dout_o
);

   for (genvar g = 0; g < ORDER; g++) begin : g_stage
      logic [ACC_W-1:0] in_v;
      logic [ACC_W-1:0] dly_q;
      logic [ACC_W-1:0] diff;

      if (g == 0) begin : g_head
         assign in_v = din_i;
      end else begin : g_tail
         assign in_v = g_stage[g-1].diff;
      end

      assign diff = in_v - dly_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     dly_q <= '0;
         else if (clr_i) dly_q <= '0;
         else if (en_i)  dly_q <= in_v;
      end
   end

   assign dout_o = g_stage[ORDER-1].diff;

endmodule

// File: rtl/sdm_decim_seq.sv
module sdm_decim_seq #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             flush_i,
   input  logic             stb_i,
   input  logic [CNT_W-1:0] ratio_i,
   input  logic [1:0]       need_i,
   input  logic             rd_i,
   output logic             tick_o,
   output logic             latch_o,
   output logic             drdy_o
);

   logic [CNT_W-1:0] dcnt_q;
   logic [1:0]       scnt_q;
   logic [2:0]       scnt_inc;

   assign tick_o   = stb_i && !restart_i && (dcnt_q == ratio_i - CNT_W'(1));
   assign scnt_inc = {1'b0, scnt_q} + 3'd1;
   assign latch_o  = tick_o && (scnt_inc >= {1'b0, need_i});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dcnt_q <= '0;
      else if (restart_i) dcnt_q <= '0;
      else if (tick_o)    dcnt_q <= '0;
      else if (stb_i)     dcnt_q <= dcnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         scnt_q <= '0;
      else if (restart_i)                 scnt_q <= '0;
      else if (tick_o && scnt_q != 2'd3)  scnt_q <= scnt_inc[1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       drdy_o <= 1'b0;
      else if (flush_i) drdy_o <= 1'b0;
      else if (latch_o) drdy_o <= 1'b1;
      else if (rd_i)    drdy_o <= 1'b0;
   end

   p_flush_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !drdy_o);

   p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i && !latch_o && !flush_i |=> !drdy_o);

   p_latch_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      latch_o && !flush_i |=> drdy_o);

   p_hold_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i && !flush_i && !rd_i && drdy_o |=> drdy_o);

   p_count_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !restart_i |-> (dcnt_q < ratio_i));

endmodule

// File: rtl/sdm_decim_ctrl.sv
module sdm_decim_ctrl
   import sdm_decim_pkg::*;
#(
   parameter int OUT_W  = 18,
   parameter int RATIO0 = 8,
   parameter int RATIO1 = 16,
   parameter int RATIO2 = 32,
   parameter int RATIO3 = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_bit_i,
   input  logic             mod_stb_i,
   input  logic             fast_sel_i,
   input  logic [1:0]       ratio_sel_i,
   input  logic             sync_hold_i,
   input  logic             cfg_chg_i,
   input  logic             rd_stb_i,
   output logic [OUT_W-1:0] result_o,
   output logic             drdy_o
);

   localparam int MAX_R     = max_of4(RATIO0, RATIO1, RATIO2, RATIO3);
   localparam int LOG_R     = $clog2(MAX_R);
   localparam int ACC_W     = SINC_ORDER * LOG_R + 1;
   localparam int CNT_W     = $clog2(MAX_R + 1);
   localparam int RTAB [4]  = '{RATIO0, RATIO1, RATIO2, RATIO3};

   for (genvar k = 0; k < 4; k++) begin : g_chk
      if (RTAB[k] < 2) begin : g_bad_ratio
         $error("decimation ratio %0d must be at least 2", k);
      end
   end
   if (OUT_W > ACC_W) begin : g_bad_width
      $error("OUT_W exceeds accumulator width");
   end

   filt_e            mode;
   logic             fast_q;
   logic [1:0]       ratio_q;
   logic             flush;
   logic             restart;
   logic             run_stb;
   logic [CNT_W-1:0] ratio_val;
   logic [1:0]       need;
   logic             tick;
   logic             latch;
   logic [ACC_W-1:0] int_first;
   logic [ACC_W-1:0] int_last;
   logic [ACC_W-1:0] comb1_out;
   logic [ACC_W-1:0] comb3_out;
   logic [ACC_W-1:0] filt_out;

   assign mode = filt_e'(fast_sel_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_q  <= 1'b0;
         ratio_q <= 2'd0;
      end else begin
         fast_q  <= fast_sel_i;
         ratio_q <= ratio_sel_i;
      end
   end

   assign flush   = cfg_chg_i || (fast_sel_i != fast_q) || (ratio_sel_i != ratio_q);
   assign restart = flush || sync_hold_i;
   assign run_stb = mod_stb_i && !restart;

   always_comb begin
      unique case (ratio_sel_i)
         2'd0:    ratio_val = CNT_W'(RATIO0);
         2'd1:    ratio_val = CNT_W'(RATIO1);
         2'd2:    ratio_val = CNT_W'(RATIO2);
         default: ratio_val = CNT_W'(RATIO3);
      endcase
   end

   assign need = (mode == FILT_SINC1) ? SETTLE_SINC1 : SETTLE_SINC3;

   sdm_integ_chain #(.ORDER(SINC_ORDER), .ACC_W(ACC_W)) u_integ (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (restart),
      .en_i    (run_stb),
      .din_i   (mod_bit_i),
      .first_o (int_first),
      .last_o  (int_last)
   );

   sdm_comb_chain #(.ORDER(SINC_ORDER), .ACC_W(ACC_W)) u_comb3 (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (restart),
      .en_i   (tick),
      .din_i  (int_last),
      .dout_o (comb3_out)
   );

   sdm_comb_chain #(.ORDER(1), .ACC_W(ACC_W)) u_comb1 (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (restart),
      .en_i   (tick),
      .din_i  (int_first),
      .dout_o (comb1_out)
   );

   sdm_decim_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart),
      .flush_i   (flush),
      .stb_i     (run_stb),
      .ratio_i   (ratio_val),
      .need_i    (need),
      .rd_i      (rd_stb_i),
      .tick_o    (tick),
      .latch_o   (latch),
      .drdy_o    (drdy_o)
   );

   assign filt_out = (mode == FILT_SINC1) ? comb1_out : comb3_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     result_o <= '0;
      else if (latch) result_o <= filt_out[ACC_W-1 -: OUT_W];
   end

   // R6 and R7: only a settled latch may move the result word
   p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> $stable(result_o));

   p_no_latch_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hold_i |-> !latch);

endmodule

// File: tb/sdm_decim_ctrl_tb.sv
module sdm_decim_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mod_bit = 1'b0;
   logic        mod_stb = 1'b0;
   logic        fast_sel = 1'b0;
   logic [1:0]  ratio_sel = 2'd0;
   logic        sync_hold = 1'b0;
   logic        cfg_chg = 1'b0;
   logic        rd_stb = 1'b0;
   logic [17:0] result;
   logic        drdy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic alt_ph = 1'b1;

   always #2 clk = ~clk;

   sdm_decim_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .mod_bit_i   (mod_bit),
      .mod_stb_i   (mod_stb),
      .fast_sel_i  (fast_sel),
      .ratio_sel_i (ratio_sel),
      .sync_hold_i (sync_hold),
      .cfg_chg_i   (cfg_chg),
      .rd_stb_i    (rd_stb),
      .result_o    (result),
      .drdy_o      (drdy)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // kind: 0 zeros, 1 ones, 2 alternating
   task automatic feed(input int n, input int kind);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         mod_stb = 1'b1;
         mod_bit = (kind == 0) ? 1'b0 : (kind == 1) ? 1'b1 : alt_ph;
         alt_ph  = ~alt_ph;
      end
      @(negedge clk);
      mod_stb = 1'b0;
   endtask

   task automatic set_cfg(input logic f, input logic [1:0] r);
      @(negedge clk);
      fast_sel  = f;
      ratio_sel = r;
      @(negedge clk);
      check("R5 drdy after config change", int'(drdy), 0);
   endtask

   task automatic do_read();
      @(negedge clk);
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic t_reset();
      check("R12 reset result", int'(result), 0);
      check("R12 reset drdy", int'(drdy), 0);
   endtask

   task automatic t_sinc3_settle();
      feed(23, 1);
      check("R3 drdy before 3R strobes", int'(drdy), 0);
      feed(1, 1);
      check("R3 drdy at 3R strobes", int'(drdy), 1);
      check("R1 R10 sinc3 ones ratio 8", int'(result), 256);
   endtask

   task automatic t_read();
      do_read();
      check("R7 read clears drdy", int'(drdy), 0);
      check("R7 read keeps result", int'(result), 256);
   endtask

   task automatic t_ratios();
      set_cfg(1'b0, 2'd1);
      feed(48, 2);
      check("R10 drdy ratio 16", int'(drdy), 1);
      check("R1 sinc3 alternating ratio 16", int'(result), 1024);
      set_cfg(1'b0, 2'd2);
      feed(95, 2);
      check("R10 drdy before 96 strobes ratio 32", int'(drdy), 0);
      feed(1, 2);
      check("R1 sinc3 alternating ratio 32", int'(result), 8192);
   endtask

   task automatic t_wrap();
      set_cfg(1'b0, 2'd3);
      feed(192, 1);
      check("R13 drdy ratio 64", int'(drdy), 1);
      check("R13 wrap result ratio 64", int'(result), 131072);
   endtask

   task automatic t_sinc1();
      set_cfg(1'b1, 2'd0);
      feed(7, 1);
      check("R4 sinc1 drdy before R", int'(drdy), 0);
      feed(1, 1);
      check("R4 sinc1 drdy at R", int'(drdy), 1);
      check("R2 sinc1 ones ratio 8", int'(result), 4);
   endtask

   task automatic t_collision();
      feed(7, 0);
      @(negedge clk);
      mod_stb = 1'b1;
      mod_bit = 1'b0;
      rd_stb  = 1'b1;
      @(negedge clk);
      mod_stb = 1'b0;
      rd_stb  = 1'b0;
      check("R8 latch beats read drdy", int'(drdy), 1);
      check("R8 latch beats read result", int'(result), 0);
      feed(8, 1);
      check("R9 overwrite result", int'(result), 4);
      check("R9 overwrite keeps drdy", int'(drdy), 1);
   endtask

   task automatic t_switch();
      set_cfg(1'b0, 2'd0);
      feed(23, 1);
      check("R5 sinc1 to sinc3 still low", int'(drdy), 0);
      feed(1, 1);
      check("R5 sinc1 to sinc3 ready", int'(drdy), 1);
      check("R1 sinc3 after switch", int'(result), 256);
   endtask

   task automatic t_cfg_pulse();
      @(negedge clk);
      cfg_chg = 1'b1;
      @(negedge clk);
      cfg_chg = 1'b0;
      check("R5 cfg pulse clears drdy", int'(drdy), 0);
      feed(24, 1);
      check("R5 ready after cfg pulse", int'(drdy), 1);
   endtask

   task automatic t_sync();
      @(negedge clk);
      sync_hold = 1'b1;
      feed(30, 0);
      check("R6 hold keeps drdy", int'(drdy), 1);
      check("R6 hold keeps result", int'(result), 256);
      do_read();
      check("R7 read during hold", int'(drdy), 0);
      @(negedge clk);
      sync_hold = 1'b0;
      feed(23, 1);
      check("R11 settle restarts after hold", int'(drdy), 0);
      feed(1, 1);
      check("R11 ready after hold release", int'(drdy), 1);
      check("R11 result after hold release", int'(result), 256);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_sinc3_settle();
      t_read();
      t_ratios();
      t_wrap();
      t_sinc1();
      t_collision();
      t_switch();
      t_cfg_pulse();
      t_sync();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule